// File: doc/BRIEF.md
# Peripheral Resource Decoder

This block turns four configuration bytes into the enable, I/O base and interrupt-line settings of the on-board peripherals. These are two serial channels, one parallel port, a primary disk interface and a floppy controller. The configuration bytes are a control byte, a serial index byte, a parallel index byte and a drive-control byte. An index byte is scaled by four to form a 10-bit I/O base. The serial interrupt is then picked by which standard base the result matches, and the same holds for the parallel interrupt.

The decoded set is held in registers and replaced only when an apply strobe is present at a clock edge. The host side raises the strobe once it leaves configuration mode. Writes to the configuration bytes before that point do not reach the peripherals. After reset, and until the first apply, the block presents a fixed default set.

Top module: `upc_res_decode`

## Requirements
- R1: The serial port is enabled by bit 2 of the control byte. When that bit is 0, an apply leaves every UART channel disabled, with base 0, IRQ number 0 and IRQ valid low.
- R2: The serial base is the serial index byte times 4. Base 0x3F8 enables channel 0 (bit 0 of `uart_en`) with IRQ 4. Base 0x2F8 enables channel 1 (bit 1) with IRQ 3. Any other base enables no channel. A disabled channel reports base 0, IRQ 0 and valid low, so at most one channel is enabled after an apply.
- R3: The parallel port is enabled by bit 3 of the control byte. When enabled, its base is the parallel index byte times 4. When disabled, its base is 0.
- R4: The parallel IRQ is 7 at base 0x378 or 0x3BC and 5 at base 0x278. At any other base, or when the port is disabled, the IRQ valid flag is low and the IRQ number is 0.
- R5: The primary disk interface enable equals bit 7 of the drive-control byte.
- R6: The floppy controller enable equals bit 5 of the drive-control byte. Its base is 0x3F0 when enabled and 0 otherwise.
- R7: Outputs change only at a clock edge where `apply` is high. At that edge they take the values decoded from the inputs present then. Input changes without `apply` have no effect on the outputs.
- R8: From reset until the first apply, the outputs are:
  - both UART channels enabled: channel 0 at 0x3F8 with IRQ 4, channel 1 at 0x2F8 with IRQ 3, both valid;
  - the parallel port enabled at 0x378 with IRQ 7, valid;
  - the disk interface and the floppy controller disabled, with floppy base 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| apply | input | 1 | Load strobe: latch newly decoded outputs at this edge |
| cfg_ctrl | input | 8 | Control byte (bit 2 serial enable, bit 3 parallel enable) |
| cfg_ser_idx | input | 8 | Serial base divided by 4 |
| cfg_par_idx | input | 8 | Parallel base divided by 4 |
| cfg_drive | input | 8 | Drive-control byte (bit 5 floppy, bit 7 disk interface) |
| uart_en | output | 2 | Per-channel UART enable |
| uart_base | output | 2x10 | Per-channel UART I/O base |
| uart_irq | output | 2x4 | Per-channel UART IRQ number |
| uart_irq_vld | output | 2 | Per-channel UART IRQ valid |
| par_en | output | 1 | Parallel port enable |
| par_base | output | 10 | Parallel I/O base |
| par_irq | output | 4 | Parallel IRQ number |
| par_irq_vld | output | 1 | Parallel IRQ valid |
| ide_en | output | 1 | Primary disk interface enable |
| fdc_en | output | 1 | Floppy controller enable |
| fdc_base | output | 10 | Floppy I/O base |

## Verification
Every decoded result goes through exactly one register. It is therefore due on the single rising edge at which `apply` is high, and the decode has no multi-cycle path. The bench drives inputs and `apply` at the falling edge and drops `apply` at the next falling edge. It compares every output at that same falling edge, half a cycle after the loading edge. The hold behaviour is checked by changing the inputs with `apply` low and comparing again two full cycles later. The reset defaults are checked once the internal reset release, two cycles long, has passed.

// File: rtl/upc_res_pkg.sv
package upc_res_pkg;
  localparam int CFG_W    = 8;
  localparam int ADDR_W   = CFG_W + 2;
  localparam int IRQ_W    = 4;
  localparam int NUM_UART = 2;

  localparam int SER_EN_BIT = 2;
  localparam int PAR_EN_BIT = 3;
  localparam int FDC_EN_BIT = 5;
  localparam int IDE_EN_BIT = 7;

  localparam logic [ADDR_W-1:0] UART_BASE [NUM_UART] = '{10'h3F8, 10'h2F8};
  localparam logic [IRQ_W-1:0]  UART_IRQ  [NUM_UART] = '{4'd4, 4'd3};

  localparam logic [ADDR_W-1:0] LPT_BASE_A = 10'h378;
  localparam logic [ADDR_W-1:0] LPT_BASE_B = 10'h3BC;
  localparam logic [ADDR_W-1:0] LPT_BASE_C = 10'h278;
  localparam logic [IRQ_W-1:0]  LPT_IRQ_HI = 4'd7;
  localparam logic [IRQ_W-1:0]  LPT_IRQ_LO = 4'd5;

  localparam logic [ADDR_W-1:0] FDC_BASE = 10'h3F0;

  function automatic logic [ADDR_W-1:0] idx_to_base(input logic [CFG_W-1:0] idx);
    return {idx, 2'b00};
  endfunction
endpackage

// File: rtl/upc_rst_sync.sv
module upc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sr_q[STAGES-1];
endmodule

// File: rtl/upc_ser_decode.sv
module upc_ser_decode
  import upc_res_pkg::*;
(
  input  logic                               enable,
  input  logic [CFG_W-1:0]                   idx,
  output logic [NUM_UART-1:0]                ch_en,
  output logic [NUM_UART-1:0][ADDR_W-1:0]    ch_base,
  output logic [NUM_UART-1:0][IRQ_W-1:0]     ch_irq,
  output logic [NUM_UART-1:0]                ch_irq_vld
);
  logic [ADDR_W-1:0] addr;
  assign addr = idx_to_base(idx);

  for (genvar i = 0; i < NUM_UART; i++) begin : g_ch
    logic hit;
    assign hit           = enable && (addr == UART_BASE[i]);
    assign ch_en[i]      = hit;
    assign ch_irq_vld[i] = hit;
    assign ch_base[i]    = hit ? addr        : '0;
    assign ch_irq[i]     = hit ? UART_IRQ[i] : '0;
  end
endmodule

// File: rtl/upc_par_decode.sv
module upc_par_decode
  import upc_res_pkg::*;
(
  input  logic              enable,
  input  logic [CFG_W-1:0]  idx,
  output logic              port_en,
  output logic [ADDR_W-1:0] port_base,
  output logic [IRQ_W-1:0]  port_irq,
  output logic              port_irq_vld
);
  logic [ADDR_W-1:0] addr;
  logic              hit_hi;
  logic              hit_lo;

  assign addr   = idx_to_base(idx);
  assign hit_hi = (addr == LPT_BASE_A) || (addr == LPT_BASE_B);
  assign hit_lo = (addr == LPT_BASE_C);

  always_comb begin
    port_en      = enable;
    port_base    = enable ? addr : '0;
    port_irq     = '0;
    port_irq_vld = 1'b0;
    if (enable && hit_hi) begin
      port_irq     = LPT_IRQ_HI;
      port_irq_vld = 1'b1;
    end else if (enable && hit_lo) begin
      port_irq     = LPT_IRQ_LO;
      port_irq_vld = 1'b1;
    end
  end
endmodule

// File: rtl/upc_drive_decode.sv
module upc_drive_decode
  import upc_res_pkg::*;
(
  input  logic [CFG_W-1:0]  drive,
  output logic              disk_en,
  output logic              flop_en,
  output logic [ADDR_W-1:0] flop_base
);
  assign disk_en   = drive[IDE_EN_BIT];
  assign flop_en   = drive[FDC_EN_BIT];
  assign flop_base = drive[FDC_EN_BIT] ? FDC_BASE : '0;
endmodule

// File: rtl/upc_res_decode.sv
module upc_res_decode
  import upc_res_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            apply,
  input  logic [CFG_W-1:0]                cfg_ctrl,
  input  logic [CFG_W-1:0]                cfg_ser_idx,
  input  logic [CFG_W-1:0]                cfg_par_idx,
  input  logic [CFG_W-1:0]                cfg_drive,
  output logic [NUM_UART-1:0]             uart_en,
  output logic [NUM_UART-1:0][ADDR_W-1:0] uart_base,
  output logic [NUM_UART-1:0][IRQ_W-1:0]  uart_irq,
  output logic [NUM_UART-1:0]             uart_irq_vld,
  output logic                            par_en,
  output logic [ADDR_W-1:0]               par_base,
  output logic [IRQ_W-1:0]                par_irq,
  output logic                            par_irq_vld,
  output logic                            ide_en,
  output logic                            fdc_en,
  output logic [ADDR_W-1:0]               fdc_base
);
  logic rst_n_s;

  upc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  // Decoded (combinational) values
  logic [NUM_UART-1:0]             dec_uen;
  logic [NUM_UART-1:0][ADDR_W-1:0] dec_ubase;
  logic [NUM_UART-1:0][IRQ_W-1:0]  dec_uirq;
  logic [NUM_UART-1:0]             dec_uvld;
  logic                            dec_pen;
  logic [ADDR_W-1:0]               dec_pbase;
  logic [IRQ_W-1:0]                dec_pirq;
  logic                            dec_pvld;
  logic                            dec_ide;
  logic                            dec_fen;
  logic [ADDR_W-1:0]               dec_fbase;

  upc_ser_decode u_ser (
    .enable     (cfg_ctrl[SER_EN_BIT]),
    .idx        (cfg_ser_idx),
    .ch_en      (dec_uen),
    .ch_base    (dec_ubase),
    .ch_irq     (dec_uirq),
    .ch_irq_vld (dec_uvld)
  );

  upc_par_decode u_par (
    .enable       (cfg_ctrl[PAR_EN_BIT]),
    .idx          (cfg_par_idx),
    .port_en      (dec_pen),
    .port_base    (dec_pbase),
    .port_irq     (dec_pirq),
    .port_irq_vld (dec_pvld)
  );

  upc_drive_decode u_drv (
    .drive     (cfg_drive),
    .disk_en   (dec_ide),
    .flop_en   (dec_fen),
    .flop_base (dec_fbase)
  );

  // Register state
  logic [NUM_UART-1:0]             uen_q,   uen_d;
  logic [NUM_UART-1:0][ADDR_W-1:0] ubase_q, ubase_d;
  logic [NUM_UART-1:0][IRQ_W-1:0]  uirq_q,  uirq_d;
  logic [NUM_UART-1:0]             uvld_q,  uvld_d;
  logic                            pen_q,   pen_d;
  logic [ADDR_W-1:0]               pbase_q, pbase_d;
  logic [IRQ_W-1:0]                pirq_q,  pirq_d;
  logic                            pvld_q,  pvld_d;
  logic                            ide_q,   ide_d;
  logic                            fen_q,   fen_d;
  logic [ADDR_W-1:0]               fbase_q, fbase_d;

  // Next state: load on apply, hold otherwise
  always_comb begin
    uen_d   = uen_q;
    ubase_d = ubase_q;
    uirq_d  = uirq_q;
    uvld_d  = uvld_q;
    pen_d   = pen_q;
    pbase_d = pbase_q;
    pirq_d  = pirq_q;
    pvld_d  = pvld_q;
    ide_d   = ide_q;
    fen_d   = fen_q;
    fbase_d = fbase_q;
    if (apply) begin
      uen_d   = dec_uen;
      ubase_d = dec_ubase;
      uirq_d  = dec_uirq;
      uvld_d  = dec_uvld;
      pen_d   = dec_pen;
      pbase_d = dec_pbase;
      pirq_d  = dec_pirq;
      pvld_d  = dec_pvld;
      ide_d   = dec_ide;
      fen_d   = dec_fen;
      fbase_d = dec_fbase;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      uen_q   <= '1;
      uvld_q  <= '1;
      pen_q   <= 1'b1;
      pbase_q <= LPT_BASE_A;
      pirq_q  <= LPT_IRQ_HI;
      pvld_q  <= 1'b1;
      ide_q   <= 1'b0;
      fen_q   <= 1'b0;
      fbase_q <= '0;
      for (int i = 0; i < NUM_UART; i++) begin
        ubase_q[i] <= UART_BASE[i];
        uirq_q[i]  <= UART_IRQ[i];
      end
    end else begin
      uen_q   <= uen_d;
      ubase_q <= ubase_d;
      uirq_q  <= uirq_d;
      uvld_q  <= uvld_d;
      pen_q   <= pen_d;
      pbase_q <= pbase_d;
      pirq_q  <= pirq_d;
      pvld_q  <= pvld_d;
      ide_q   <= ide_d;
      fen_q   <= fen_d;
      fbase_q <= fbase_d;
    end
  end

  assign uart_en      = uen_q;
  assign uart_base    = ubase_q;
  assign uart_irq     = uirq_q;
  assign uart_irq_vld = uvld_q;
  assign par_en       = pen_q;
  assign par_base     = pbase_q;
  assign par_irq      = pirq_q;
  assign par_irq_vld  = pvld_q;
  assign ide_en       = ide_q;
  assign fdc_en       = fen_q;
  assign fdc_base     = fbase_q;
endmodule

// File: rtl/upc_res_decode_chk.sv
module upc_res_decode_chk
  import upc_res_pkg::*;
(
  input logic                            clk,
  input logic                            rst_n,
  input logic                            apply,
  input logic [CFG_W-1:0]                cfg_ctrl,
  input logic [CFG_W-1:0]                cfg_drive,
  input logic [NUM_UART-1:0]             uart_en,
  input logic [NUM_UART-1:0][ADDR_W-1:0] uart_base,
  input logic [NUM_UART-1:0]             uart_irq_vld,
  input logic                            par_en,
  input logic [ADDR_W-1:0]               par_base,
  input logic                            par_irq_vld,
  input logic                            ide_en,
  input logic                            fdc_en,
  input logic [ADDR_W-1:0]               fdc_base
);
  AST_SER_OFF_AFTER_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && !cfg_ctrl[SER_EN_BIT]) |=> (uart_en == '0)); // R1

  AST_UART_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> $onehot0(uart_en)); // R2

  AST_UART_VLD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_irq_vld & ~uart_en) == '0); // R2

  AST_PAR_OFF_BASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !par_en |-> (par_base == '0)); // R3

  AST_PAR_VLD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !par_en |-> !par_irq_vld); // R4

  AST_IDE_FOLLOWS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> (ide_en == $past(cfg_drive[IDE_EN_BIT]))); // R5

  AST_FDC_BASE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    fdc_en |-> (fdc_base == FDC_BASE)); // R6

  AST_HOLD_NO_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> ($stable(uart_en) && $stable(uart_base) && $stable(par_base)
                && $stable(par_en) && $stable(ide_en) && $stable(fdc_en))); // R7
endmodule

bind upc_res_decode upc_res_decode_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .apply        (apply),
  .cfg_ctrl     (cfg_ctrl),
  .cfg_drive    (cfg_drive),
  .uart_en      (uart_en),
  .uart_base    (uart_base),
  .uart_irq_vld (uart_irq_vld),
  .par_en       (par_en),
  .par_base     (par_base),
  .par_irq_vld  (par_irq_vld),
  .ide_en       (ide_en),
  .fdc_en       (fdc_en),
  .fdc_base     (fdc_base)
);

// File: tb/upc_res_decode_tb_top.sv
module upc_res_decode_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n;
  logic apply;
  logic [7:0] cfg_ctrl, cfg_ser_idx, cfg_par_idx, cfg_drive;
  logic [1:0]       uart_en;
  logic [1:0][9:0]  uart_base;
  logic [1:0][3:0]  uart_irq;
  logic [1:0]       uart_irq_vld;
  logic             par_en;
  logic [9:0]       par_base;
  logic [3:0]       par_irq;
  logic             par_irq_vld;
  logic             ide_en;
  logic             fdc_en;
  logic [9:0]       fdc_base;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  upc_res_decode dut_i (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Compare all outputs with the values decoded from the given bytes
  task automatic expect_all(input int ctl, input int sv, input int pv, input int dv);
    int sa = sv * 4;
    int pa = pv * 4;
    int ue0 = 0, ue1 = 0, pen, pirq = 0, pvld = 0;
    if ((ctl & 4) != 0 && sa == 'h3F8) ue0 = 1;
    if ((ctl & 4) != 0 && sa == 'h2F8) ue1 = 1;
    pen = ((ctl & 8) != 0) ? 1 : 0;
    if (pen == 1 && (pa == 'h378 || pa == 'h3BC)) begin pirq = 7; pvld = 1; end
    else if (pen == 1 && pa == 'h278) begin pirq = 5; pvld = 1; end
    if ((ctl & 4) == 0) chk("R1", "uart_en(off)", int'(uart_en), 0);
    chk("R2", "uart_en", int'(uart_en), ue1 * 2 + ue0);
    chk("R2", "uart0 base", int'(uart_base[0]), ue0 ? sa : 0);
    chk("R2", "uart1 base", int'(uart_base[1]), ue1 ? sa : 0);
    chk("R2", "uart0 irq", int'(uart_irq[0]), ue0 ? 4 : 0);
    chk("R2", "uart1 irq", int'(uart_irq[1]), ue1 ? 3 : 0);
    chk("R2", "uart vld", int'(uart_irq_vld), ue1 * 2 + ue0);
    chk("R3", "par_en", int'(par_en), pen);
    chk("R3", "par_base", int'(par_base), pen ? pa : 0);
    chk("R4", "par_irq", int'(par_irq), pirq);
    chk("R4", "par_irq_vld", int'(par_irq_vld), pvld);
    chk("R5", "ide_en", int'(ide_en), (dv >> 7) & 1);
    chk("R6", "fdc_en", int'(fdc_en), (dv >> 5) & 1);
    chk("R6", "fdc_base", int'(fdc_base), ((dv >> 5) & 1) ? 'h3F0 : 0);
  endtask

  task automatic do_apply(input int ctl, input int sv, input int pv, input int dv);
    @(negedge clk);
    cfg_ctrl = 8'(ctl); cfg_ser_idx = 8'(sv); cfg_par_idx = 8'(pv); cfg_drive = 8'(dv);
    apply = 1'b1;
    @(negedge clk);
    apply = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; apply = 1'b0;
    cfg_ctrl = 8'h0C; cfg_ser_idx = 8'hFE; cfg_par_idx = 8'h9E; cfg_drive = 8'hA0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8: defaults before first apply
    chk("R8", "uart_en", int'(uart_en), 3);
    chk("R8", "uart0 base", int'(uart_base[0]), 'h3F8);
    chk("R8", "uart1 base", int'(uart_base[1]), 'h2F8);
    chk("R8", "uart0 irq", int'(uart_irq[0]), 4);
    chk("R8", "uart1 irq", int'(uart_irq[1]), 3);
    chk("R8", "uart vld", int'(uart_irq_vld), 3);
    chk("R8", "par_en", int'(par_en), 1);
    chk("R8", "par_base", int'(par_base), 'h378);
    chk("R8", "par_irq", int'(par_irq), 7);
    chk("R8", "par_irq_vld", int'(par_irq_vld), 1);
    chk("R8", "ide_en", int'(ide_en), 0);
    chk("R8", "fdc_en", int'(fdc_en), 0);
    chk("R8", "fdc_base", int'(fdc_base), 0);

    // R1..R6: sweep every index value under each enable combination
    for (int v = 0; v < 256; v++) begin
      for (int c = 0; c < 4; c++) begin
        int ctl = (c << 2) | ((v & 3) ^ 3) | (v & 8'hF0);
        int pv  = v ^ ((c & 1) ? 8'h00 : 8'h41);
        int dv  = (v * 7 + c * 32) & 8'hFF;
        do_apply(ctl, v, pv, dv);
        expect_all(ctl, v, pv, dv);
      end
    end

    // R4: every parallel base that carries an interrupt, enabled
    do_apply(8'h08, 8'h00, 8'hDE, 8'h00); expect_all(8'h08, 0, 'hDE, 0);
    do_apply(8'h08, 8'h00, 8'hEF, 8'h00); expect_all(8'h08, 0, 'hEF, 0);
    do_apply(8'h08, 8'h00, 8'h9E, 8'h00); expect_all(8'h08, 0, 'h9E, 0);

    // R7: input changes without apply are ignored
    do_apply(8'h0C, 8'hFE, 8'h9E, 8'hA0);
    @(negedge clk);
    cfg_ctrl = 8'h00; cfg_ser_idx = 8'hBE; cfg_par_idx = 8'h00; cfg_drive = 8'h00;
    repeat (2) @(negedge clk);
    expect_all(8'h0C, 'hFE, 'h9E, 'hA0);
    chk("R7", "uart_en held", int'(uart_en), 1);
    chk("R7", "par_base held", int'(par_base), 'h278);
    // R7: the next apply takes the current inputs
    apply = 1'b1;
    @(negedge clk);
    apply = 1'b0;
    chk("R7", "uart_en loaded", int'(uart_en), 0);
    chk("R7", "fdc_en loaded", int'(fdc_en), 0);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (50000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule